// File: doc/BRIEF.md
# Bus Controller Retry Sequencer

This block sits inside the bus controller of a dual-redundant serial command/response bus. It paces one command block at a time. It requests a command block and launches its first transmission attempt. It then waits for the outcome of that attempt. The outcome is one of four results: success, no reply from the terminal, terminal busy, or message error flagged in the terminal's status. From this result, the per-block control word and a set of retry configuration inputs, the block decides whether to send the message again and on which of the two buses. When the last allowed retry also fails, it raises a single-cycle interrupt.

The block also keeps a minimum start-to-start spacing between command blocks. An elapsed-time counter starts with the first attempt of each block. The next block is requested only once the programmed interval, counted in units of `UNIT_CYC` clock cycles, has been met. If retries run past that interval, the next block is requested at once. Execution begins on a start pulse, a new start pulse abandons whatever is in flight, and nothing runs after a reset until the next start pulse. Word transmission and the memory fetch of command blocks are done by neighbouring logic.

Top module: `bc_retry_seq`

## Requirements
- R1: After reset `blk_req`, `msg_go` and `irq_exhaust` are low, and no block is requested or launched (even with `blk_valid` high) until `start_en` is pulsed.
- R2: A `start_en` pulse makes `blk_req` high in the next cycle from any state. A result presented in the same cycle is discarded: it causes no retry and no interrupt.
- R3: When `blk_valid` is high while `blk_req` is high, the next cycle carries a one-cycle `msg_go` with `msg_try` = 0 and `msg_bus` = control word bit 8 (1 = bus B), and `blk_req` is low.
- R4: Control word bit 9 enables retries for the block. `res_code` is 0 = success, 1 = no reply, 2 = busy, 3 = message error. Code 1 is retry-eligible. Code 2 is eligible only with `cfg_busy_en`. Code 3 is eligible only with `cfg_merr_en`. Code 0 never is. An eligible result with budget left gives a retry `msg_go` in the cycle after `res_valid`.
- R5: A block is sent at most `cfg_retry_num`+1 extra times. `msg_try` numbers the attempts 0, 1, 2, and so on.
- R6: Retries go out on the bus opposite to the first attempt when `cfg_opp_bus` is 1, and on the same bus when it is 0.
- R7: `irq_exhaust` pulses for one cycle, in the cycle after an eligible failure that finds no retry budget left. It never pulses for a success, for an ineligible failure, or when bit 9 is clear.
- R8: Control word bits 7:0 times `UNIT_CYC` give the cycle distance between consecutive first-attempt `msg_go` pulses. This holds when the block finished earlier and the next block is already available.
- R9: While a block's result is outstanding, no new block is requested. If the final result arrives after the spacing is already met, `blk_req` rises in the next cycle.
- R10: The retry count starts from zero for every block, including a block that follows one which succeeded on a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Start or restart pulse |
| cfg_retry_num | input | 2 | Extra attempts allowed, minus one |
| cfg_opp_bus | input | 1 | Send retries on the opposite bus |
| cfg_busy_en | input | 1 | Retry on busy result |
| cfg_merr_en | input | 1 | Retry on message error result |
| blk_req | output | 1 | Request for the next command block |
| blk_valid | input | 1 | Command block control word available |
| blk_ctrl | input | 16 | Control word: [9] retry enable, [8] bus, [7:0] spacing |
| msg_go | output | 1 | Launch one transmission attempt |
| msg_bus | output | 1 | Bus for this attempt (1 = B) |
| msg_try | output | 3 | Attempt number, 0 = first |
| res_valid | input | 1 | Attempt result valid |
| res_code | input | 2 | Attempt result code |
| irq_exhaust | output | 1 | All retries failed |

## Verification
Retry exhaustion and the spacing overrun can fall on the same clock edge. The last failing result both triggers the interrupt and, because the interval has already elapsed, triggers the immediate request for the next block. The bench provokes this by holding back the first result well past a short spacing interval. It then fails the single allowed retry. It judges that `irq_exhaust` and `blk_req` are both high in the cycle after that result, with no further `msg_go`. A second same-cycle case pairs a restart pulse with an eligible failure, and checks that neither a retry nor an interrupt follows.

// File: rtl/bc_retry_pkg.sv
package bc_retry_pkg;

  // attempt result codes
  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_NORESP = 2'd1,
    RES_BUSY   = 2'd2,
    RES_MERR   = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SPACE = 2'd3
  } seq_state_e;

  // control word field positions
  localparam int CW_GAP_LSB = 0;
  localparam int CW_BUS_BIT = 8;
  localparam int CW_RTY_BIT = 9;

endpackage

// File: rtl/bc_gap_timer.sv
module bc_gap_timer #(
  parameter int GAP_W    = 8,
  parameter int UNIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [GAP_W-1:0] gap,
  output logic             due
);
  localparam int LIM_MAX = ((1 << GAP_W) - 1) * UNIT_CYC;
  localparam int EL_W    = $clog2(LIM_MAX + 3) + 1;

  logic [EL_W-1:0] elapsed;
  logic [EL_W:0]   limit;
  logic [EL_W:0]   ahead;

  // elapsed counts cycles since the first attempt, saturating
  always_ff @(posedge clk) begin
    if (rst || arm) begin
      elapsed <= '0;
    end else if (elapsed != {EL_W{1'b1}}) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // due: a launch issued after the next request lands at or past the limit
  always_comb begin
    limit = (EL_W+1)'(gap) * (EL_W+1)'(UNIT_CYC);
    ahead = {1'b0, elapsed} + (EL_W+1)'(2);
    due   = (ahead >= limit);
  end
endmodule

// File: rtl/bc_retry_judge.sv
module bc_retry_judge
  import bc_retry_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter int TRY_W = 3
) (
  input  logic [1:0]       res_code,
  input  logic             blk_rty_en,
  input  logic             busy_en,
  input  logic             merr_en,
  input  logic [CNT_W-1:0] retry_num,
  input  logic [TRY_W-1:0] used,
  output logic             do_retry,
  output logic             do_irq
);
  res_e             code;
  logic             eligible;
  logic [TRY_W-1:0] budget;
  logic             has_budget;

  always_comb begin
    code = res_e'(res_code);
    unique case (code)
      RES_NORESP: eligible = blk_rty_en;
      RES_BUSY:   eligible = blk_rty_en && busy_en;
      RES_MERR:   eligible = blk_rty_en && merr_en;
      default:    eligible = 1'b0;
    endcase
    budget     = TRY_W'(retry_num) + TRY_W'(1);
    has_budget = (used < budget);
    do_retry   = eligible && has_budget;
    do_irq     = eligible && !has_budget;
  end
endmodule

// File: rtl/bc_retry_seq.sv
module bc_retry_seq
  import bc_retry_pkg::*;
#(
  parameter int UNIT_CYC = 4,
  parameter int CW_W     = 16,
  parameter int GAP_W    = 8,
  parameter int CNT_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_en,
  input  logic [CNT_W-1:0] cfg_retry_num,
  input  logic            cfg_opp_bus,
  input  logic            cfg_busy_en,
  input  logic            cfg_merr_en,
  output logic            blk_req,
  input  logic            blk_valid,
  input  logic [CW_W-1:0] blk_ctrl,
  output logic            msg_go,
  output logic            msg_bus,
  output logic [2:0]      msg_try,
  input  logic            res_valid,
  input  logic [1:0]      res_code,
  output logic            irq_exhaust
);
  localparam int TRY_W = 3;

  seq_state_e      state;
  logic [CW_W-1:0] cw_q;
  logic            first_bus;
  logic            arm_first;
  logic            due;
  logic            do_retry;
  logic            do_irq;
  logic            retry_bus;

  assign arm_first = (state == ST_FETCH) && blk_valid && !start_en;
  assign retry_bus = cfg_opp_bus ? ~first_bus : first_bus;

  bc_gap_timer #(
    .GAP_W   (GAP_W),
    .UNIT_CYC(UNIT_CYC)
  ) u_gap (
    .clk(clk),
    .rst(rst),
    .arm(arm_first),
    .gap(cw_q[CW_GAP_LSB +: GAP_W]),
    .due(due)
  );

  bc_retry_judge #(
    .CNT_W(CNT_W),
    .TRY_W(TRY_W)
  ) u_judge (
    .res_code  (res_code),
    .blk_rty_en(cw_q[CW_RTY_BIT]),
    .busy_en   (cfg_busy_en),
    .merr_en   (cfg_merr_en),
    .retry_num (cfg_retry_num),
    .used      (msg_try),
    .do_retry  (do_retry),
    .do_irq    (do_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cw_q        <= '0;
      first_bus   <= 1'b0;
      blk_req     <= 1'b0;
      msg_go      <= 1'b0;
      msg_bus     <= 1'b0;
      msg_try     <= '0;
      irq_exhaust <= 1'b0;
    end else begin
      msg_go      <= 1'b0;
      irq_exhaust <= 1'b0;
      if (start_en) begin
        state   <= ST_FETCH;
        blk_req <= 1'b1;
      end else begin
        unique case (state)
          ST_FETCH: begin
            if (blk_valid) begin
              cw_q      <= blk_ctrl;
              first_bus <= blk_ctrl[CW_BUS_BIT];
              msg_bus   <= blk_ctrl[CW_BUS_BIT];
              msg_try   <= '0;
              msg_go    <= 1'b1;
              blk_req   <= 1'b0;
              state     <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (res_valid) begin
              if (do_retry) begin
                msg_go  <= 1'b1;
                msg_bus <= retry_bus;
                msg_try <= msg_try + 1'b1;
              end else begin
                irq_exhaust <= do_irq;
                if (due) begin
                  blk_req <= 1'b1;
                  state   <= ST_FETCH;
                end else begin
                  state <= ST_SPACE;
                end
              end
            end
          end
          ST_SPACE: begin
            if (due) begin
              blk_req <= 1'b1;
              state   <= ST_FETCH;
            end
          end
          default: begin
            state <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bc_retry_seq_chk.sv
module bc_retry_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_en,
  input logic       cfg_opp_bus,
  input logic       blk_req,
  input logic       blk_valid,
  input logic       msg_go,
  input logic       msg_bus,
  input logic [2:0] msg_try,
  input logic       res_valid,
  input logic       irq_exhaust
);
  logic seen_bus;

  always_ff @(posedge clk) begin
    if (rst) seen_bus <= 1'b0;
    else if (msg_go && msg_try == 3'd0) seen_bus <= msg_bus;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!msg_go && !blk_req && !irq_exhaust)); // R1

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_en |=> blk_req); // R2

  AST_FIRST_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    (msg_go && msg_try == 3'd0) |-> $past(blk_req && blk_valid)); // R3

  AST_GO_NOT_REQ: assert property (@(posedge clk) disable iff (rst)
    msg_go |-> !blk_req); // R3

  AST_RETRY_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (msg_go && msg_try != 3'd0) |-> $past(res_valid && !start_en)); // R4

  AST_RETRY_BUS: assert property (@(posedge clk) disable iff (rst)
    (msg_go && msg_try != 3'd0) |-> (msg_bus == (cfg_opp_bus ? ~seen_bus : seen_bus))); // R6

  AST_IRQ_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    irq_exhaust |-> $past(res_valid && !start_en)); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_exhaust |=> !irq_exhaust); // R7

  AST_IRQ_NO_GO: assert property (@(posedge clk) disable iff (rst)
    irq_exhaust |-> !msg_go); // R7
endmodule

bind bc_retry_seq bc_retry_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_en   (start_en),
  .cfg_opp_bus(cfg_opp_bus),
  .blk_req    (blk_req),
  .blk_valid  (blk_valid),
  .msg_go     (msg_go),
  .msg_bus    (msg_bus),
  .msg_try    (msg_try),
  .res_valid  (res_valid),
  .irq_exhaust(irq_exhaust)
);

// File: tb/bc_retry_seq_test.sv
module bc_retry_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_en = 1'b0;
  logic [1:0]  cfg_retry_num = 2'd0;
  logic        cfg_opp_bus = 1'b0;
  logic        cfg_busy_en = 1'b0;
  logic        cfg_merr_en = 1'b0;
  logic        blk_req;
  logic        blk_valid = 1'b0;
  logic [15:0] blk_ctrl = 16'd0;
  logic        msg_go;
  logic        msg_bus;
  logic [2:0]  msg_try;
  logic        res_valid = 1'b0;
  logic [1:0]  res_code = 2'd0;
  logic        irq_exhaust;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  bc_retry_seq uut (
    .clk(clk), .rst(rst), .start_en(start_en),
    .cfg_retry_num(cfg_retry_num), .cfg_opp_bus(cfg_opp_bus),
    .cfg_busy_en(cfg_busy_en), .cfg_merr_en(cfg_merr_en),
    .blk_req(blk_req), .blk_valid(blk_valid), .blk_ctrl(blk_ctrl),
    .msg_go(msg_go), .msg_bus(msg_bus), .msg_try(msg_try),
    .res_valid(res_valid), .res_code(res_code), .irq_exhaust(irq_exhaust)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // num, opp, busy_en, merr_en, first bus, retry bit, fail code,
  // failures before success (5 = never), expected launches, expected irq
  typedef struct packed {
    logic [1:0] num;
    logic       opp;
    logic       busy_en;
    logic       merr_en;
    logic       bus;
    logic       rty;
    logic [1:0] code;
    logic [2:0] fails;
    logic [2:0] exp_tries;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd5, 3'd2, 1'b1},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd5, 3'd5, 1'b1},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 3'd1, 3'd2, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 3'd5, 3'd1, 1'b0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 3'd5, 3'd3, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 3'd5, 3'd1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 3'd5, 3'd2, 1'b1},
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 3'd5, 3'd1, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 3'd0, 3'd1, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 3'd3, 1'b0},
    // R10: follows a block that succeeded on a retry, full budget expected
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 3'd5, 3'd5, 1'b1},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 3'd5, 3'd3, 1'b1},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 3'd0, 3'd1, 1'b0}
  };

  task automatic wait_req();
    while (!blk_req) @(negedge clk);
  endtask

  task automatic wait_go();
    @(negedge clk);
    while (!msg_go) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int c0;
    int c1;
    int tries;
    int irqs;
    bit exp_bus;

    // R1: reset state, blk_valid ignored before start
    blk_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!blk_req && !msg_go && !irq_exhaust, "R1", "reset outputs",
          {blk_req, msg_go, irq_exhaust}, 0);
    tries = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (msg_go || blk_req) tries++;
    end
    check(tries == 0, "R1", "activity before start", tries, 0);
    blk_valid = 1'b0;

    // R2: start pulse raises the request next cycle
    start_en = 1'b1;
    @(negedge clk);
    start_en = 1'b0;
    check(blk_req == 1'b1, "R2", "request after start", blk_req, 1);

    // table of result scenarios (R4 R5 R6 R7 R10)
    for (int v = 0; v < NV; v++) begin
      cfg_retry_num = VECS[v].num;
      cfg_opp_bus   = VECS[v].opp;
      cfg_busy_en   = VECS[v].busy_en;
      cfg_merr_en   = VECS[v].merr_en;
      blk_ctrl      = {6'd0, VECS[v].rty, VECS[v].bus, 8'd0};
      wait_req();
      blk_valid = 1'b1;
      @(negedge clk);
      blk_valid = 1'b0;
      tries = 0;
      irqs  = 0;
      for (int a = 0; a < 6; a++) begin
        if (!msg_go) break;
        tries++;
        if (a == 0)
          check(!blk_req, "R3", "request dropped at launch", blk_req, 0);
        check(msg_try == 3'(a), "R5", "attempt number", msg_try, a);
        exp_bus = (a == 0) ? VECS[v].bus
                           : (VECS[v].opp ? ~VECS[v].bus : VECS[v].bus);
        check(msg_bus == exp_bus, "R6", "attempt bus", msg_bus, exp_bus);
        res_valid = 1'b1;
        res_code  = (a < int'(VECS[v].fails)) ? VECS[v].code : 2'd0;
        @(negedge clk);
        res_valid = 1'b0;
        if (irq_exhaust) irqs++;
      end
      check(tries == int'(VECS[v].exp_tries), "R4", $sformatf("launches vec %0d", v),
            tries, VECS[v].exp_tries);
      check(irqs == int'(VECS[v].exp_irq), "R7", $sformatf("interrupt vec %0d", v),
            irqs, VECS[v].exp_irq);
    end

    // R2: restart in the same cycle as an eligible failure
    cfg_retry_num = 2'd3;
    cfg_opp_bus   = 1'b0;
    blk_ctrl      = 16'h0200;
    wait_req();
    blk_valid = 1'b1;
    wait_go();
    blk_valid = 1'b0;
    start_en  = 1'b1;
    res_valid = 1'b1;
    res_code  = 2'd1;
    @(negedge clk);
    start_en  = 1'b0;
    res_valid = 1'b0;
    check(!msg_go && blk_req && !irq_exhaust, "R2", "restart over result",
          {msg_go, blk_req, irq_exhaust}, 2);

    // R8: start-to-start spacing of 5 units of 4 cycles
    blk_ctrl  = 16'h0005;
    blk_valid = 1'b1;
    wait_go();
    c0 = cyc;
    res_valid = 1'b1;
    res_code  = 2'd0;
    @(negedge clk);
    res_valid = 1'b0;
    while (!msg_go) @(negedge clk);
    c1 = cyc;
    blk_valid = 1'b0;
    check(c1 - c0 == 20, "R8", "launch spacing", c1 - c0, 20);
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;

    // R9 and R7 together: retries overrun a short spacing, final failure
    cfg_retry_num = 2'd0;
    blk_ctrl      = 16'h0202;
    wait_req();
    blk_valid = 1'b1;
    wait_go();
    blk_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(!blk_req, "R9", "no request while result pending", blk_req, 0);
    res_valid = 1'b1;
    res_code  = 2'd1;
    @(negedge clk);
    check(msg_go && msg_try == 3'd1, "R5", "single retry", msg_try, 1);
    res_code = 2'd1;
    @(negedge clk);
    res_valid = 1'b0;
    check(irq_exhaust, "R7", "interrupt on last failure", irq_exhaust, 1);
    check(blk_req, "R9", "immediate next request", blk_req, 1);
    check(!msg_go, "R5", "no launch past budget", msg_go, 0);
    @(negedge clk);
    check(!irq_exhaust, "R7", "interrupt one cycle", irq_exhaust, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule